// File: doc/BRIEF.md
# Fixed-Point Streaming Low-Pass FIR Filter

This block is a direct-form finite impulse response filter for a sample stream. Each cycle in which the input strobe is high, it accepts one signed 16-bit sample in Q2.14. It multiplies the new sample and the stored past samples by a fixed coefficient set and adds up every product at full precision. It then narrows the sum back to Q2.14 and delivers it through a registered output, together with a one-cycle valid flag.

The coefficient set is computed when the block is elaborated, not loaded at run time. It is a symmetric triangular low-pass kernel: coefficient k equals STEP times min(k+1, NTAPS-k), stored in Q2.14. The default is 100 taps (order 99) with STEP = 6, which gives a DC gain a little below one. The history starts at zero after reset, so the very first response equals the first coefficient times the first input. That response is flagged valid like every later one.

Top module: `fir_lowpass`

## Requirements
- R1: While reset is asserted and until the first accepted input, out_sample is 0 and out_valid is 0.
- R2: The first accepted input after reset produces an output with out_valid high, equal to floor(coef[0] * x0 / 2^14), because all past history is zero.
- R3: For each accepted sample n, out_sample is y[n] = sat(floor(sum over k of coef[k] * x[n-k] / 2^14)), where x[n-k] is the k-th previously accepted sample and any sample from before the last reset counts as zero.
- R4: out_valid is high in exactly the cycle after a clock edge at which in_valid was high, and low after an edge at which in_valid was low. The output of an accepted sample is visible one clock after that sample is latched.
- R5: An edge with in_valid low leaves out_sample unchanged and does not advance the history, whatever value in_sample carries.
- R6: When the narrowed sum lies outside the signed 16-bit range, out_sample saturates to 32767 (positive) or to -32768 (negative) and does not wrap.
- R7: Each product is kept at full precision in Q4.28, and the sum carries ceil(log2(NTAPS)) extra integer bits (Q11.28 for 100 taps). A stream of full-scale samples of either sign therefore gives the exact, saturated result.
- R8: Coefficient k equals STEP * min(k+1, NTAPS-k) in Q2.14. A single input of 16384 (1.0) followed by zeros makes out_sample equal to coef[k] for the k-th output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Input sample, signed Q2.14 |
| out_valid | output | 1 | High for one cycle with each new output |
| out_sample | output | 16 | Filtered output, signed Q2.14 |

## Verification
Each output is due exactly one clock after the edge that latches its input. The bench drives in_valid and in_sample on the falling edge and checks on the next falling edge, after the single output register has taken the new value. At that point it compares out_valid against the strobe of the previous cycle and out_sample against a software model. The model shifts its own history only on accepted samples, so gap cycles check both the hold and the no-shift behaviour. A second instance with a much larger coefficient step runs on the same stream to reach saturation and the full-scale sums.

// File: rtl/fir_lp_pkg.sv
package fir_lp_pkg;

  // Symmetric triangular low-pass kernel, Q2.14 integer value of tap k.
  function automatic int tri_coef(input int k, input int ntaps, input int step);
    int rise;
    int fall;
    rise = k + 1;
    fall = ntaps - k;
    return step * ((rise < fall) ? rise : fall);
  endfunction

endpackage

// File: rtl/fir_tap_store.sv
module fir_tap_store #(
  parameter int NTAPS = 100,
  parameter int DW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_en,
  input  logic [DW-1:0]         din,
  output logic [NTAPS*DW-1:0]   taps
);
  localparam int NHIST = NTAPS - 1;

  logic [DW-1:0] hist_q [NHIST];
  logic [DW-1:0] hist_d [NHIST];

  // Tap 0 is the incoming sample; tap k is the k-th previous accepted sample.
  assign taps[DW-1:0] = din;

  for (genvar i = 0; i < NHIST; i++) begin : g_stage
    always_comb begin
      if (i == 0) hist_d[i] = shift_en ? din : hist_q[i];
      else        hist_d[i] = shift_en ? hist_q[(i > 0) ? i-1 : 0] : hist_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q[i] <= '0;
      else        hist_q[i] <= hist_d[i];
    end

    assign taps[(i+1)*DW +: DW] = hist_q[i];
  end
endmodule

// File: rtl/fir_mac.sv
module fir_mac
  import fir_lp_pkg::*;
#(
  parameter int NTAPS = 100,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int STEP  = 6,
  parameter int ACCW  = 39
) (
  input  logic [NTAPS*DW-1:0]    taps,
  output logic signed [ACCW-1:0] acc
);
  localparam int PW = DW + CW;

  logic signed [PW-1:0] prod [NTAPS];

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    localparam logic signed [CW-1:0] CK = CW'(tri_coef(k, NTAPS, STEP));
    assign prod[k] = $signed(taps[k*DW +: DW]) * CK;
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAPS; k++) begin
      acc = acc + ACCW'(prod[k]);
    end
  end
endmodule

// File: rtl/fir_out_stage.sv
module fir_out_stage #(
  parameter int ACCW = 39,
  parameter int DW   = 16,
  parameter int FRAC = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic signed [ACCW-1:0] acc,
  output logic signed [DW-1:0]  out_sample,
  output logic                  out_valid
);
  localparam logic signed [ACCW-1:0] MAXV = ACCW'((2 ** (DW-1)) - 1);
  localparam logic signed [ACCW-1:0] MINV = -ACCW'(2 ** (DW-1));

  logic signed [ACCW-1:0] shifted;
  logic signed [DW-1:0]   narrowed;
  logic signed [DW-1:0]   sample_d;
  logic                   valid_d;

  always_comb begin
    shifted = acc >>> FRAC;
    if (shifted > MAXV)      narrowed = DW'(MAXV);
    else if (shifted < MINV) narrowed = DW'(MINV);
    else                     narrowed = DW'(shifted);
    sample_d = load ? narrowed : out_sample;
    valid_d  = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sample <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_sample <= sample_d;
      out_valid  <= valid_d;
    end
  end
endmodule

// File: rtl/fir_lowpass.sv
module fir_lowpass #(
  parameter int NTAPS = 100,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int FRAC  = 14,
  parameter int STEP  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample
);
  localparam int GUARD = $clog2(NTAPS);
  localparam int ACCW  = DW + CW + GUARD;

  logic [NTAPS*DW-1:0]   taps;
  logic signed [ACCW-1:0] acc;

  fir_tap_store #(.NTAPS(NTAPS), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
    .din(in_sample), .taps(taps)
  );

  fir_mac #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .STEP(STEP), .ACCW(ACCW)) u_mac (
    .taps(taps), .acc(acc)
  );

  fir_out_stage #(.ACCW(ACCW), .DW(DW), .FRAC(FRAC)) u_out (
    .clk(clk), .rst_n(rst_n), .load(in_valid), .acc(acc),
    .out_sample(out_sample), .out_valid(out_valid)
  );
endmodule

// File: rtl/fir_lowpass_chk.sv
module fir_lowpass_chk #(
  parameter int NTAPS = 100,
  parameter int DW    = 16,
  parameter int FRAC  = 14,
  parameter int STEP  = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_sample,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_sample
);
  logic seen_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_any <= 1'b0;
    else if (in_valid) seen_any <= 1'b1;
  end

  function automatic logic signed [DW-1:0] first_expect(input logic signed [DW-1:0] x);
    longint p;
    p = longint'(x) * longint'(fir_lp_pkg::tri_coef(0, NTAPS, STEP));
    p = p >>> FRAC;
    if (p > longint'((2 ** (DW-1)) - 1)) p = longint'((2 ** (DW-1)) - 1);
    if (p < -longint'(2 ** (DW-1)))      p = -longint'(2 ** (DW-1));
    return DW'(p);
  endfunction

  a_r4_valid_after_input: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sample));

  a_r2_first_zero_history: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !seen_any) |=> (out_sample == first_expect($past(in_sample))));
endmodule

bind fir_lowpass fir_lowpass_chk #(
  .NTAPS(NTAPS), .DW(DW), .FRAC(FRAC), .STEP(STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
  .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/fir_lowpass_test.sv
module fir_lowpass_test;
  localparam int N      = 100;
  localparam int STEP_A = 6;
  localparam int STEP_B = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [15:0] in_sample;
  logic va, vb;
  logic signed [15:0] oa, ob;

  always #2 clk = ~clk;

  fir_lowpass #(.STEP(STEP_A)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(va), .out_sample(oa)
  );

  fir_lowpass #(.STEP(STEP_B)) uut_hot (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(vb), .out_sample(ob)
  );

  int hist [N];
  int n_chk = 0;
  int n_bad = 0;
  bit exp_v;
  int exp_a, exp_b;
  bit first_pending, first_now;
  string ph;
  bit done = 0;

  function automatic int coef(int k, int step);
    int r = k + 1;
    int f = N - k;
    return step * ((r < f) ? r : f);
  endfunction

  function automatic int model(int step);
    longint s = 0;
    for (int k = 0; k < N; k++) s += longint'(hist[k]) * longint'(coef(k, step));
    s = s >>> 14;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle(bit v, int x);
    string ta, tb;
    @(negedge clk);
    check("R4", "valid uut", int'(va), int'(exp_v));
    check("R4", "valid uut_hot", int'(vb), int'(exp_v));
    if (!exp_v) begin
      ta = "R5"; tb = "R5";
    end else if (first_now) begin
      ta = "R2"; tb = "R2";
    end else begin
      ta = ph;
      tb = (exp_b == 32767 || exp_b == -32768) ? "R6" : ph;
    end
    check(ta, "out uut", int'(oa), exp_a);
    check(tb, "out uut_hot", int'(ob), exp_b);
    in_valid  = v;
    in_sample = 16'(x);
    first_now = 1'b0;
    if (v) begin
      for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = int'($signed(16'(x)));
      exp_a = model(STEP_A);
      exp_b = model(STEP_B);
      first_now = first_pending;
      first_pending = 1'b0;
    end
    exp_v = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sample = '0;
    for (int k = 0; k < N; k++) hist[k] = 0;
    exp_v = 1'b0; exp_a = 0; exp_b = 0;
    first_pending = 1'b1; first_now = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "valid in reset", int'(va), 0);
    check("R1", "out in reset", int'(oa), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid after reset", int'(vb), 0);
    check("R1", "out after reset", int'(ob), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sample = '0;
    void'($urandom(32'd2718));
    ph = "R3";
    do_reset();
    cycle(1, 32767);
    for (int i = 0; i < 500; i++) cycle(($urandom % 10) < 7, int'($urandom));
    ph = "R8";
    do_reset();
    cycle(1, 16384);
    for (int i = 0; i < N + 3; i++) cycle(1, 0);
    ph = "R3";
    cycle(1, 1000);
    for (int i = 0; i < 6; i++) cycle(0, int'($urandom));
    cycle(1, -20000);
    ph = "R7";
    for (int i = 0; i < 120; i++) cycle(1, -32768);
    for (int i = 0; i < 120; i++) cycle(1, 32767);
    for (int i = 0; i < 120; i++) cycle(1, (i % 2 == 0) ? 32767 : -32768);
    cycle(0, 0);
    cycle(0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule